// File: doc/BRIEF.md
# Receive FIFO Idle Detector

This block sits beside a serial receiver's FIFO. It raises a flag when the line has gone quiet while unread characters are still waiting. A counter advances on each bit-rate tick. It runs only while the FIFO holds at least one entry and detection is enabled. When more than `IDLE_BITS` bit times pass with no new start bit and no FIFO read, the idle flag is set. If the receive interrupt is enabled, the flag also drives an interrupt request. Software can then collect a partial burst that would never fill the FIFO up to its level trigger.

The FIFO pop strobe comes from a read of the shared data address. That same address pushes the transmit FIFO when it is written. Only the read strobe reaches this block. A start bit or a pop restarts the count. Once the count passes the threshold it saturates, so a quiet line cannot set the flag again. The flag then stays set until software clears it, the FIFO drains, or detection is turned off.

Top module: `rxq_idle_detector`

## Requirements
- R1: After reset, `idle_flag` and `rx_irq` are 0.
- R2: While `rxq_nonempty` is 0, bit ticks are not counted and `idle_flag` stays 0.
- R3: With the FIFO non-empty and detection enabled, `idle_flag` rises on the clock edge that takes the (`IDLE_BITS`+1)-th bit tick after the last restart. It is still 0 after `IDLE_BITS` ticks (default 8, so it is set on the 9th tick).
- R4: A pulse on `rx_start_det` restarts the bit-time count from zero.
- R5: A pulse on `rxq_pop` restarts the bit-time count from zero.
- R6: While `idle_det_en` is 0, no idle flag is produced. Dropping it clears a set flag on the next edge.
- R7: `rx_irq` is 1 exactly when `idle_flag` is 1 and `rx_irq_en` is 1, in the same cycle.
- R8: Once set, `idle_flag` stays 1 through further ticks. A pulse on `idle_clr` clears it on the next edge.
- R9: When `rxq_nonempty` falls to 0, `idle_flag` clears on the next edge.
- R10: After the count has passed the threshold it saturates. Further ticks with no restart never set the flag again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxq_nonempty | input | 1 | Receive FIFO holds at least one entry |
| rx_start_det | input | 1 | Receiver detected a start bit (pulse) |
| baud_tick | input | 1 | One pulse per bit time |
| idle_det_en | input | 1 | Idle detection enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rxq_pop | input | 1 | Receive FIFO read strobe from the shared data address |
| idle_clr | input | 1 | Software clear of the idle flag (pulse) |
| idle_flag | output | 1 | Idle condition detected |
| rx_irq | output | 1 | Receive interrupt request from idle detection |

## Verification
The flag is registered. It sets on the same clock edge that samples the threshold-crossing tick. It clears one edge after `idle_clr`, an empty FIFO or a disable. The interrupt follows the flag and its enable with no added cycle. The bench drives every input at the falling edge and holds a tick for exactly one rising edge. It samples at the next falling edge, so each check reads the value that the single intervening rising edge produced. Threshold checks are taken both after `IDLE_BITS` ticks and after one more tick, so that an off-by-one shows up.

// File: rtl/rxq_idle_pkg.sv
// Package: shared types for the receive FIFO idle detector.
// Assumes: nothing beyond IEEE 1800-2017.
package rxq_idle_pkg;

    // Control seen by the bit-time counter in one cycle
    typedef struct packed {
        logic active;   // FIFO non-empty and detection enabled
        logic restart;  // start bit, FIFO pop, or inactive
    } cnt_ctrl_t;

endpackage

// File: rtl/rxq_bit_timer.sv
// Module: rxq_bit_timer
// Counts bit ticks since the last restart and saturates one past LIMIT.
// Emits a one-cycle expire pulse on the tick that crosses LIMIT.
// Assumes: baud_tick is a single-cycle pulse; ctrl.restart covers inactivity.
module rxq_bit_timer
    import rxq_idle_pkg::*;
#(
    parameter int IDLE_BITS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cnt_ctrl_t ctrl,
    input  logic      baud_tick,
    output logic      expire
);
    localparam int              SAT_VAL = IDLE_BITS + 1;
    localparam int              CNT_W   = $clog2(SAT_VAL + 1);
    localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(IDLE_BITS);
    localparam logic [CNT_W-1:0] SAT    = CNT_W'(SAT_VAL);

    logic [CNT_W-1:0] cnt_q;

    // Crossing pulse: tick arriving with count at the limit and no restart
    always_comb begin
        expire = ctrl.active && !ctrl.restart && baud_tick && (cnt_q == LIMIT);
    end

    // Counter: clear on restart, advance on tick, hold at saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ctrl.restart) begin
            cnt_q <= '0;
        end else if (baud_tick && (cnt_q != SAT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);                                            // R10
    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.restart |=> (cnt_q == '0));                          // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.restart && !baud_tick) |=> $stable(cnt_q));        // R3

endmodule

// File: rtl/rxq_idle_flag.sv
// Module: rxq_idle_flag
// Sticky idle flag: set by the timer's expire pulse, cleared by software,
// by an empty FIFO or by disabling detection.
// Assumes: expire is a single-cycle pulse.
module rxq_idle_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic sw_clr,
    input  logic fifo_nonempty,
    input  logic det_en,
    output logic flag
);
    // Flag register: any clear source wins over a set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (sw_clr || !fifo_nonempty || !det_en) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end
    end

    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> !flag);                                        // R8
    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_nonempty |=> !flag);                                // R9
    AST_DISABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !flag);                                       // R6
    AST_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));                           // R3

endmodule

// File: rtl/rxq_idle_detector.sv
// Module: rxq_idle_detector (top)
// Watches a receive FIFO for a quiet line while data waits and raises an
// idle flag and interrupt after more than IDLE_BITS bit times.
// Assumes: rxq_pop is the pop strobe decoded from reads of the shared
// receive/transmit data address; all inputs are synchronous to clk.
module rxq_idle_detector
    import rxq_idle_pkg::*;
#(
    parameter int IDLE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxq_nonempty,
    input  logic rx_start_det,
    input  logic baud_tick,
    input  logic idle_det_en,
    input  logic rx_irq_en,
    input  logic rxq_pop,
    input  logic idle_clr,
    output logic idle_flag,
    output logic rx_irq
);
    cnt_ctrl_t ctrl;
    logic      expire;

    // Counter control: active only with data waiting and detection on
    always_comb begin
        ctrl.active  = rxq_nonempty && idle_det_en;
        ctrl.restart = !ctrl.active || rx_start_det || rxq_pop;
    end

    rxq_bit_timer #(
        .IDLE_BITS (IDLE_BITS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .baud_tick (baud_tick),
        .expire    (expire)
    );

    rxq_idle_flag u_flag (
        .clk           (clk),
        .rst_n         (rst_n),
        .expire        (expire),
        .sw_clr        (idle_clr),
        .fifo_nonempty (rxq_nonempty),
        .det_en        (idle_det_en),
        .flag          (idle_flag)
    );

    // Interrupt request: idle flag gated by the receive interrupt enable
    always_comb begin
        rx_irq = idle_flag && rx_irq_en;
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> rx_irq_en);                             // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> idle_flag);                                    // R7

endmodule

// File: tb/rxq_idle_detector_bench.sv
module rxq_idle_detector_bench;
    localparam int IDLE_BITS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxq_nonempty = 1'b0, rx_start_det = 1'b0, baud_tick = 1'b0;
    logic idle_det_en = 1'b0, rx_irq_en = 1'b0, rxq_pop = 1'b0, idle_clr = 1'b0;
    logic idle_flag, rx_irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rxq_idle_detector #(.IDLE_BITS(IDLE_BITS)) u_rxq_idle_detector (
        .clk(clk), .rst_n(rst_n), .rxq_nonempty(rxq_nonempty),
        .rx_start_det(rx_start_det), .baud_tick(baud_tick),
        .idle_det_en(idle_det_en), .rx_irq_en(rx_irq_en), .rxq_pop(rxq_pop),
        .idle_clr(idle_clr), .idle_flag(idle_flag), .rx_irq(rx_irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Each tick is high for one rising edge; returns at a falling edge
    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Restart the count by emptying then refilling the FIFO
    task automatic refill();
        rxq_nonempty = 1'b0;
        @(negedge clk);
        rxq_nonempty = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(idle_flag, 1'b0, "R1 flag after reset");
        check(rx_irq, 1'b0, "R1 irq after reset");
    endtask

    task automatic t_empty();
        idle_det_en = 1'b1;
        rxq_nonempty = 1'b0;
        ticks(20);
        check(idle_flag, 1'b0, "R2 no flag while FIFO empty");
    endtask

    task automatic t_threshold();
        rx_irq_en = 1'b0;
        refill();
        ticks(IDLE_BITS);
        check(idle_flag, 1'b0, "R3 flag still low at threshold");
        ticks(1);
        check(idle_flag, 1'b1, "R3 flag set one tick past threshold");
        check(rx_irq, 1'b0, "R7 irq masked by enable");
        rx_irq_en = 1'b1;
        #1;
        check(rx_irq, 1'b1, "R7 irq follows flag when enabled");
        ticks(5);
        idle_cycles(3);
        check(idle_flag, 1'b1, "R8 flag holds");
        idle_clr = 1'b1;
        @(negedge clk);
        idle_clr = 1'b0;
        check(idle_flag, 1'b0, "R8 flag cleared by software");
        check(rx_irq, 1'b0, "R7 irq drops with flag");
        ticks(20);
        check(idle_flag, 1'b0, "R10 saturated count does not re-trigger");
    endtask

    task automatic t_start();
        refill();
        ticks(5);
        rx_start_det = 1'b1;
        @(negedge clk);
        rx_start_det = 1'b0;
        ticks(IDLE_BITS);
        check(idle_flag, 1'b0, "R4 start bit restarted count");
        ticks(1);
        check(idle_flag, 1'b1, "R4 flag after restarted count");
        rxq_nonempty = 1'b0;
        @(negedge clk);
        check(idle_flag, 1'b0, "R9 flag cleared when FIFO empties");
    endtask

    task automatic t_pop();
        refill();
        ticks(7);
        rxq_pop = 1'b1;
        @(negedge clk);
        rxq_pop = 1'b0;
        ticks(IDLE_BITS);
        check(idle_flag, 1'b0, "R5 pop restarted count");
        ticks(1);
        check(idle_flag, 1'b1, "R5 flag after restarted count");
        // Tick coincident with pop: pop wins
        idle_clr = 1'b1;
        @(negedge clk);
        idle_clr = 1'b0;
        refill();
        ticks(IDLE_BITS);
        rxq_pop = 1'b1;
        baud_tick = 1'b1;
        @(negedge clk);
        rxq_pop = 1'b0;
        baud_tick = 1'b0;
        check(idle_flag, 1'b0, "R5 pop beats crossing tick");
    endtask

    task automatic t_disable();
        idle_det_en = 1'b0;
        refill();
        ticks(20);
        check(idle_flag, 1'b0, "R6 no flag while disabled");
        idle_det_en = 1'b1;
        @(negedge clk);
        ticks(IDLE_BITS + 1);
        check(idle_flag, 1'b1, "R6 flag once enabled");
        idle_det_en = 1'b0;
        @(negedge clk);
        check(idle_flag, 1'b0, "R6 disable clears flag");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_threshold();
        t_start();
        t_pop();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule